// File: doc/BRIEF.md
# Key Event Queue with Overflow Hold

This block sits between a keypad scanner and a host register interface. The scanner presents a complete key-event record on a wide data port together with a one-cycle write strobe. The queue keeps up to four such records in arrival order. The host takes them out one byte per read strobe, and the queue releases a record only once its last byte has been read.

A configuration input states whether direct (dedicated) keys are in use. When it is set, each record carries three bytes. When it is clear, each record carries two bytes and the top byte of the record port is ignored. Changing this setting empties the queue, so records of different widths never sit in storage together.

A data interrupt stays high while any unread record remains. When the queue is full, a further record is thrown away and the stored records are left untouched. That lost record sets a sticky overflow interrupt, which the host clears with a clear strobe. Loading resumes as soon as a record has been fully read.

Top module: `key_event_queue`

## Requirements
- R1: After reset, `data_irq` and `ovf_irq` are 0 and `rd_data` is 0xFF.
- R2: With `direct_en` = 0, successive read strobes return bits [7:0] of a record and then bits [15:8]. Bits [23:16] are never returned.
- R3: With `direct_en` = 1, successive read strobes return bits [7:0], then [15:8], then [23:16] of a record.
- R4: Records are read out in the order they were written, and up to four are held at once.
- R5: `data_irq` is 1 from the cycle after a record is accepted until the cycle after the last byte of the last unread record is read.
- R6: A write strobe while four records are held discards the incoming record, leaves the stored records and their order unchanged, and sets `ovf_irq` on the next cycle.
- R7: `ovf_irq` stays 1 until a cycle with `ovf_clr` = 1 and no discarded write. A discard in the same cycle as `ovf_clr` keeps the flag set.
- R8: A read strobe while the queue is empty sets `rd_data` to 0xFF on the next cycle and moves no pointer.
- R9: In any cycle where `direct_en` differs from its value in the previous cycle, the queue is emptied. A write or read in that cycle is ignored.
- R10: A read that does not reach the last byte of a record keeps that record queued, and `data_irq` stays 1.
- R11: Once a full queue has had one record completely read, the next write is accepted and read out after the older records.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| direct_en | input | 1 | 1 selects three-byte records, 0 selects two-byte records |
| rec_wr | input | 1 | One-cycle strobe that loads `rec_data` |
| rec_data | input | 24 | Record; byte 0 in [7:0], byte 1 in [15:8], byte 2 in [23:16] |
| rd_stb | input | 1 | One-cycle strobe that reads the next byte |
| rd_data | output | 8 | Byte from the most recent read strobe, registered |
| ovf_clr | input | 1 | Clears the overflow flag |
| data_irq | output | 1 | High while an unread record remains |
| ovf_irq | output | 1 | Sticky overflow flag |

## Verification
The assertions check on every cycle that the record count stays bounded, that a discarded write leaves the count unchanged and raises overflow, that overflow holds until cleared, that an empty read yields 0xFF, and that a configuration change empties the queue. Byte order within a record, record order across the queue, and the fact that a discarded record leaves the older contents intact all depend on data values over long sequences. Only the bench's write-and-read scenarios can show these behaviours, including the three-byte mode and the flush that follows a mode change.

// File: rtl/kq_pkg.sv
package kq_pkg;
   localparam int unsigned KQ_BYTE_W = 8;
   typedef logic [KQ_BYTE_W-1:0] kq_byte_t;
   localparam kq_byte_t KQ_EMPTY_BYTE = 8'hFF;
endpackage

// File: rtl/kq_store.sv
module kq_store #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned REC_W = 24,
   localparam int unsigned PW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [PW-1:0]    wr_ptr,
   input  logic [REC_W-1:0] wr_rec,
   input  logic [PW-1:0]    rd_ptr,
   output logic [REC_W-1:0] rd_rec
);
   logic [REC_W-1:0] slot_arr [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [REC_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_ptr == PW'(g))) begin
            slot_q <= wr_rec;
         end
      end
      assign slot_arr[g] = slot_q;
   end

   assign rd_rec = slot_arr[rd_ptr];
endmodule

// File: rtl/kq_bytesel.sv
module kq_bytesel
   import kq_pkg::*;
#(
   parameter int unsigned NBYTES = 3,
   localparam int unsigned REC_W = NBYTES * KQ_BYTE_W,
   localparam int unsigned IW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic [REC_W-1:0] rec,
   input  logic [IW-1:0]    idx,
   output kq_byte_t         byte_o
);
   kq_byte_t lane [NBYTES];

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign lane[b] = rec[b*KQ_BYTE_W +: KQ_BYTE_W];
   end

   always_comb begin
      byte_o = KQ_EMPTY_BYTE;
      for (int i = 0; i < NBYTES; i++) begin
         if (idx == IW'(i)) byte_o = lane[i];
      end
   end
endmodule

// File: rtl/kq_ctrl.sv
module kq_ctrl
   import kq_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned NBYTES = 3,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1),
   localparam int unsigned IW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          direct_en,
   input  logic          rec_wr,
   input  logic          rd_stb,
   input  logic          ovf_clr,
   input  kq_byte_t      sel_byte,
   output logic          push,
   output logic [PW-1:0] tail_q,
   output logic [PW-1:0] head_q,
   output logic [IW-1:0] idx_q,
   output kq_byte_t      rd_data,
   output logic          data_irq,
   output logic          ovf_irq
);
   logic          cfg_q, flush, full, empty, rd_do, pop, drop;
   logic [CW-1:0] count_q, count_n;
   logic [IW-1:0] last_idx;

   assign flush    = (direct_en != cfg_q);
   assign full     = (count_q == CW'(DEPTH));
   assign empty    = (count_q == '0);
   assign last_idx = direct_en ? IW'(NBYTES - 1) : IW'(NBYTES - 2);
   assign push     = rec_wr && !full && !flush;
   assign drop     = rec_wr && full && !flush;
   assign rd_do    = rd_stb && !empty && !flush;
   assign pop      = rd_do && (idx_q == last_idx);

   always_comb begin
      count_n = count_q;
      if (push && !pop) count_n = count_q + CW'(1);
      else if (pop && !push) count_n = count_q - CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= 1'b0;
         head_q  <= '0;
         tail_q  <= '0;
         idx_q   <= '0;
         count_q <= '0;
      end else begin
         cfg_q <= direct_en;
         if (flush) begin
            head_q  <= '0;
            tail_q  <= '0;
            idx_q   <= '0;
            count_q <= '0;
         end else begin
            count_q <= count_n;
            if (push) tail_q <= tail_q + PW'(1);
            if (pop) begin
               head_q <= head_q + PW'(1);
               idx_q  <= '0;
            end else if (rd_do) begin
               idx_q <= idx_q + IW'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= KQ_EMPTY_BYTE;
         ovf_irq <= 1'b0;
      end else begin
         if (rd_stb) rd_data <= rd_do ? sel_byte : KQ_EMPTY_BYTE;
         if (drop) ovf_irq <= 1'b1;
         else if (ovf_clr) ovf_irq <= 1'b0;
      end
   end

   assign data_irq = !empty;

   // R4
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));
   // R6
   drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !rd_stb) |=> (count_q == $past(count_q)));
   // R6
   drop_raises_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovf_irq);
   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_irq && !ovf_clr) |=> ovf_irq);
   // R8
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && empty && !flush && !rec_wr) |=> (rd_data == KQ_EMPTY_BYTE && count_q == '0));
   // R9
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !data_irq);
   // R5
   push_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> data_irq);
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
   import kq_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned NBYTES = 3,
   localparam int unsigned REC_W = NBYTES * KQ_BYTE_W,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned IW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             direct_en,
   input  logic             rec_wr,
   input  logic [REC_W-1:0] rec_data,
   input  logic             rd_stb,
   output logic [7:0]       rd_data,
   input  logic             ovf_clr,
   output logic             data_irq,
   output logic             ovf_irq
);
   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
      assert (NBYTES >= 2)
         else $error("NBYTES must be at least 2");
   end

   logic             push;
   logic [PW-1:0]    tail_q, head_q;
   logic [IW-1:0]    idx_q;
   logic [REC_W-1:0] head_rec;
   kq_byte_t         sel_byte;

   kq_store #(.DEPTH(DEPTH), .REC_W(REC_W)) u_store (
      .clk    (clk),
      .wr_en  (push),
      .wr_ptr (tail_q),
      .wr_rec (rec_data),
      .rd_ptr (head_q),
      .rd_rec (head_rec)
   );

   kq_bytesel #(.NBYTES(NBYTES)) u_sel (
      .rec    (head_rec),
      .idx    (idx_q),
      .byte_o (sel_byte)
   );

   kq_ctrl #(.DEPTH(DEPTH), .NBYTES(NBYTES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .direct_en (direct_en),
      .rec_wr    (rec_wr),
      .rd_stb    (rd_stb),
      .ovf_clr   (ovf_clr),
      .sel_byte  (sel_byte),
      .push      (push),
      .tail_q    (tail_q),
      .head_q    (head_q),
      .idx_q     (idx_q),
      .rd_data   (rd_data),
      .data_irq  (data_irq),
      .ovf_irq   (ovf_irq)
   );
endmodule

// File: tb/key_event_queue_test.sv
module key_event_queue_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        direct_en = 1'b0;
   logic        rec_wr = 1'b0;
   logic [23:0] rec_data = '0;
   logic        rd_stb = 1'b0;
   logic        ovf_clr = 1'b0;
   logic [7:0]  rd_data;
   logic        data_irq, ovf_irq;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   key_event_queue uut (
      .clk(clk), .rst_n(rst_n), .direct_en(direct_en), .rec_wr(rec_wr),
      .rec_data(rec_data), .rd_stb(rd_stb), .rd_data(rd_data),
      .ovf_clr(ovf_clr), .data_irq(data_irq), .ovf_irq(ovf_irq)
   );

   // op: 0 write, 1 read and compare byte, 2 compare {ovf,data} irqs, 3 pulse clear
   localparam int NV = 32;
   localparam logic [37:0] VEC [NV] = '{
      {2'd0, 4'd2,  24'h002211, 8'h00},  // R2 write
      {2'd0, 4'd4,  24'h004433, 8'h00},  // R4 second record
      {2'd2, 4'd5,  24'h0,      8'h01},  // R5 irq set
      {2'd1, 4'd2,  24'h0,      8'h11},  // R2 low byte first
      {2'd2, 4'd10, 24'h0,      8'h01},  // R10 partial read keeps record
      {2'd1, 4'd2,  24'h0,      8'h22},  // R2 second byte
      {2'd1, 4'd4,  24'h0,      8'h33},  // R4 next record
      {2'd1, 4'd4,  24'h0,      8'h44},  // R4
      {2'd2, 4'd5,  24'h0,      8'h00},  // R5 irq drops
      {2'd1, 4'd8,  24'h0,      8'hFF},  // R8 empty read
      {2'd0, 4'd4,  24'h550B0A, 8'h00},  // R4 fill
      {2'd0, 4'd4,  24'h550D0C, 8'h00},
      {2'd0, 4'd4,  24'h550F0E, 8'h00},
      {2'd0, 4'd4,  24'h551110, 8'h00},
      {2'd2, 4'd6,  24'h0,      8'h01},  // R6 full, no overflow yet
      {2'd0, 4'd6,  24'h009988, 8'h00},  // R6 discarded
      {2'd2, 4'd6,  24'h0,      8'h03},  // R6 overflow raised
      {2'd1, 4'd6,  24'h0,      8'h0A},  // R6 old head intact
      {2'd1, 4'd6,  24'h0,      8'h0B},
      {2'd0, 4'd11, 24'h007766, 8'h00},  // R11 accepted after drain
      {2'd1, 4'd6,  24'h0,      8'h0C},
      {2'd1, 4'd6,  24'h0,      8'h0D},
      {2'd1, 4'd6,  24'h0,      8'h0E},
      {2'd1, 4'd6,  24'h0,      8'h0F},
      {2'd1, 4'd6,  24'h0,      8'h10},
      {2'd1, 4'd6,  24'h0,      8'h11},
      {2'd1, 4'd11, 24'h0,      8'h66},  // R11 new record last
      {2'd1, 4'd11, 24'h0,      8'h77},
      {2'd2, 4'd7,  24'h0,      8'h02},  // R7 ovf still set
      {2'd3, 4'd7,  24'h0,      8'h00},  // R7 clear
      {2'd2, 4'd7,  24'h0,      8'h00},  // R7 cleared
      {2'd1, 4'd8,  24'h0,      8'hFF}   // R8
   };

   task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [23:0] d);
      @(negedge clk); rec_wr = 1'b1; rec_data = d;
      @(negedge clk); rec_wr = 1'b0;
   endtask

   task automatic do_rd(output logic [7:0] b);
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0; b = rd_data;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] b;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(1, rd_data, 8'hFF);
      chk(1, {6'd0, ovf_irq, data_irq}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         case (VEC[i][37:36])
            2'd0: do_wr(VEC[i][31:8]);
            2'd1: begin do_rd(b); chk(int'(VEC[i][35:32]), b, VEC[i][7:0]); end
            2'd2: chk(int'(VEC[i][35:32]), {6'd0, ovf_irq, data_irq}, VEC[i][7:0]);
            default: begin
               @(negedge clk); ovf_clr = 1'b1;
               @(negedge clk); ovf_clr = 1'b0;
            end
         endcase
      end

      // R3 three-byte records
      @(negedge clk); direct_en = 1'b1;
      @(negedge clk);
      do_wr(24'h332211);
      do_wr(24'h665544);
      do_rd(b); chk(3, b, 8'h11);
      do_rd(b); chk(3, b, 8'h22);
      chk(10, {7'd0, data_irq}, 8'h01);  // R10 mid-record
      do_rd(b); chk(3, b, 8'h33);
      do_rd(b); chk(3, b, 8'h44);

      // R9 mode change flushes, write in the change cycle ignored
      @(negedge clk); direct_en = 1'b0; rec_wr = 1'b1; rec_data = 24'h00ABCD;
      @(negedge clk); rec_wr = 1'b0;
      chk(9, {7'd0, data_irq}, 8'h00);
      do_rd(b); chk(9, b, 8'hFF);
      do_wr(24'h000201);
      do_rd(b); chk(9, b, 8'h01);
      do_rd(b); chk(9, b, 8'h02);
      chk(9, {7'd0, data_irq}, 8'h00);

      // R7 discard in the clear cycle keeps the flag
      for (int k = 0; k < 4; k++) do_wr(24'h000000 + 24'(k));
      @(negedge clk); rec_wr = 1'b1; ovf_clr = 1'b1; rec_data = 24'h00EEEE;
      @(negedge clk); rec_wr = 1'b0; ovf_clr = 1'b0;
      chk(7, {7'd0, ovf_irq}, 8'h01);
      do_rd(b); chk(6, b, 8'h00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule